// File: doc/BRIEF.md
# SPI Slave Front End with Hold

This block is the serial slave front end of a small addressable peripheral. It runs on a fast system clock and synchronizes the serial clock, chip select, hold and serial data lines into that domain. Each transfer is framed by chip select being low. The first byte carries a 4-bit device address in its upper nibble and an instruction code in its lower nibble. Every later byte is handed to the core on a parallel strobe interface.

Read data leaves the block most significant bit first. The core offers a byte and a request flag. At each byte boundary the block loads that byte and drives it out on the falling serial clock edges that follow. A hold line lets the master pause a transfer without losing its place.

After reset the block stays disarmed until it sees chip select fall. Frames whose address nibble does not match the parameter bits and strap pins are ignored until chip select rises.

Top module: `spi_hold_slave`

## Requirements
- R1: Serial data is sampled on rising serial clock edges, most significant bit first. After the address byte, each group of 8 bits produces a one-cycle `rx_valid_o` pulse with the byte on `rx_data_o`.
- R2: The first byte of a frame is split into two nibbles. The upper nibble is the address, and it matches when it equals {`DEV_ID_HI`, `addr_strap_i`}, with `DEV_ID_HI` in bits 7:6 and the strap in bits 5:4. On a match, the lower nibble appears on `instr_o` with a one-cycle `instr_valid_o` pulse.
- R3: When the address does not match, the rest of the frame produces no strobes and leaves `sdo_oe_o` low until chip select rises.
- R4: While chip select is high, `sdo_oe_o` is low and the bit sequence returns to idle. The next frame starts again at the address byte.
- R5: After reset no frame is accepted until chip select has gone from high to low. A chip select that is already low at reset release arms nothing.
- R6: The block enters pause only when hold falls while the serial clock is low. It leaves pause only when hold rises while the serial clock is low. While paused, serial clock edges are ignored, and the bit count and shift state are kept.
- R7: While paused, `sdo_oe_o` is low. It returns high when the pause ends.
- R8: When `rd_req_i` is high at a byte boundary (the end of a matched address byte or of a data byte), `rd_data_i` is loaded. Its bits, most significant first, appear on `sdo_o` after the next eight falling serial clock edges, with `sdo_oe_o` high. A boundary without a request ends driving.
- R9: If chip select rises in the middle of a byte, the partial byte is discarded and no strobe is produced.
- R10: A hold falling edge while the serial clock is high does not pause the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from master |
| cs_ni | input | 1 | Chip select, active low |
| hold_ni | input | 1 | Hold/pause, active low |
| sdi_i | input | 1 | Serial data in |
| addr_strap_i | input | 2 | Low two bits of the device address |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` (low means high impedance) |
| instr_o | output | 4 | Instruction nibble from the address byte |
| instr_valid_o | output | 1 | One-cycle strobe for `instr_o` |
| rx_data_o | output | 8 | Received data byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_data_o` |
| rd_req_i | input | 1 | Request to shift out `rd_data_i` from the next byte boundary |
| rd_data_i | input | 8 | Parallel byte to transmit |

## Verification
The bench builds the block with `DEV_ID_HI` set to 2'b01 and a strap of 2'b10, so the matching address nibble is 4'b0110. A mismatch can then be produced simply by changing one strap bit. `SYNC_STAGES` stays at 2, and each serial half-period is 8 system clocks. That is long enough for every synchronized edge to settle before the next one, which lets the bench place pause entry, pause exit, a hold edge during the high phase and a mid-byte deselect at exact points within a byte.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_ADDR = 2'd1,
    FR_DATA = 2'd2,
    FR_SKIP = 2'd3
  } frame_st_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned      WIDTH   = 1,
  parameter int unsigned      STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_ni,
  input  logic sck_i,
  input  logic cs_ni,
  output logic paused_o
);
  logic hold_q, paused_q;
  logic hold_fall, hold_rise;

  assign hold_fall = hold_q & ~hold_ni;
  assign hold_rise = ~hold_q & hold_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= 1'b1;
      paused_q <= 1'b0;
    end else begin
      hold_q <= hold_ni;
      if (cs_ni) paused_q <= 1'b0;
      else if (!sck_i) begin
        // hold edges count only in the low phase of the serial clock
        if (hold_fall)      paused_q <= 1'b1;
        else if (hold_rise) paused_q <= 1'b0;
      end
    end
  end

  assign paused_o = paused_q;
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_hold_pkg::*;
#(
  parameter logic [1:0] DEV_ID_HI = 2'b10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              bit_stb_i,
  input  logic              shift_stb_i,
  input  logic              sdi_i,
  input  logic [1:0]        strap_i,
  input  logic              rd_req_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [NIB_W-1:0]  instr_o,
  output logic              instr_valid_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              sdo_o,
  output logic              tx_on_o,
  output frame_st_e         state_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);
  frame_st_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q, rx_q, byte_w;
  logic [NIB_W-1:0]  instr_q;
  logic              rx_v_q, ins_v_q, tx_on_q, sdo_q;
  logic              active, byte_done, addr_hit, boundary;

  assign active    = (st_q == FR_ADDR) || (st_q == FR_DATA);
  assign byte_w    = {sh_q[BYTE_W-2:0], sdi_i};
  assign byte_done = bit_stb_i && active && (cnt_q == CNT_W'(BYTE_W-1));
  assign addr_hit  = byte_w[BYTE_W-1 -: NIB_W] == {DEV_ID_HI, strap_i};
  assign boundary  = byte_done && ((st_q == FR_DATA) || addr_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= FR_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      instr_q <= '0;
      rx_v_q  <= 1'b0;
      ins_v_q <= 1'b0;
      tx_on_q <= 1'b0;
      sdo_q   <= 1'b0;
    end else begin
      rx_v_q  <= 1'b0;
      ins_v_q <= 1'b0;
      if (abort_i) begin
        st_q    <= FR_IDLE;
        cnt_q   <= '0;
        tx_on_q <= 1'b0;
      end else if (start_i) begin
        st_q    <= FR_ADDR;
        cnt_q   <= '0;
        tx_on_q <= 1'b0;
      end else begin
        if (bit_stb_i && active) begin
          sh_q  <= byte_w;
          cnt_q <= cnt_q + 1'b1;
        end
        if (byte_done) begin
          if (st_q == FR_ADDR) begin
            if (addr_hit) begin
              st_q    <= FR_DATA;
              instr_q <= byte_w[NIB_W-1:0];
              ins_v_q <= 1'b1;
            end else begin
              st_q <= FR_SKIP;
            end
          end else begin
            rx_q   <= byte_w;
            rx_v_q <= 1'b1;
          end
        end
        if (boundary) begin
          tx_on_q <= rd_req_i;
          if (rd_req_i) tx_q <= rd_data_i;
        end
        if (shift_stb_i && tx_on_q) begin
          sdo_q <= tx_q[BYTE_W-1];
          tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign instr_o       = instr_q;
  assign instr_valid_o = ins_v_q;
  assign rx_data_o     = rx_q;
  assign rx_valid_o    = rx_v_q;
  assign sdo_o         = sdo_q;
  assign tx_on_o       = tx_on_q;
  assign state_o       = st_q;
  assign bit_cnt_o     = cnt_q;
endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave
  import spi_hold_pkg::*;
#(
  parameter logic [1:0]  DEV_ID_HI   = 2'b10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sck_i,
  input  logic        cs_ni,
  input  logic        hold_ni,
  input  logic        sdi_i,
  input  logic [1:0]  addr_strap_i,
  output logic        sdo_o,
  output logic        sdo_oe_o,
  output logic [3:0]  instr_o,
  output logic        instr_valid_o,
  output logic [7:0]  rx_data_o,
  output logic        rx_valid_o,
  input  logic        rd_req_i,
  input  logic [7:0]  rd_data_i
);
  localparam int unsigned NSYNC = 4;
  // order {sck, cs_n, hold_n, sdi}; cs resets low so a held-low select is no edge
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b0010;

  logic [NSYNC-1:0] sync_s;
  logic sck_s, cs_s, hold_s, sdi_s;
  logic sck_q, cs_q, armed_q;
  logic sck_rise, sck_fall, cs_fall;
  logic paused, tx_on;
  logic bit_stb, shift_stb;
  frame_st_e state;
  logic [CNT_W-1:0] bit_cnt;

  spi_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, cs_ni, hold_ni, sdi_i}),
    .q_o   (sync_s)
  );
  assign {sck_s, cs_s, hold_s, sdi_s} = sync_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= 1'b0;
      cs_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
      if (cs_fall) armed_q <= 1'b1;
    end
  end

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign cs_fall  = cs_q & ~cs_s;

  spi_hold_ctrl u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_ni (hold_s),
    .sck_i   (sck_s),
    .cs_ni   (cs_s),
    .paused_o(paused)
  );

  assign bit_stb   = sck_rise & ~paused & ~cs_s & armed_q;
  assign shift_stb = sck_fall & ~paused & ~cs_s & armed_q;

  spi_frame #(.DEV_ID_HI(DEV_ID_HI)) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (cs_fall),
    .abort_i      (cs_s),
    .bit_stb_i    (bit_stb),
    .shift_stb_i  (shift_stb),
    .sdi_i        (sdi_s),
    .strap_i      (addr_strap_i),
    .rd_req_i     (rd_req_i),
    .rd_data_i    (rd_data_i),
    .instr_o      (instr_o),
    .instr_valid_o(instr_valid_o),
    .rx_data_o    (rx_data_o),
    .rx_valid_o   (rx_valid_o),
    .sdo_o        (sdo_o),
    .tx_on_o      (tx_on),
    .state_o      (state),
    .bit_cnt_o    (bit_cnt)
  );

  assign sdo_oe_o = tx_on & ~paused & ~cs_s;
endmodule

// File: rtl/spi_hold_checker.sv
module spi_hold_checker
  import spi_hold_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_s,
  input logic             paused,
  input logic             armed_q,
  input logic             sdo_oe_o,
  input logic             rx_valid_o,
  input logic             instr_valid_o,
  input frame_st_e        state,
  input logic [CNT_W-1:0] bit_cnt
);
  assert_one_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_valid_o, instr_valid_o}));

  assert_instr_enters_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o |-> state == FR_DATA);

  assert_skip_silent_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == FR_SKIP) |-> (!sdo_oe_o && !rx_valid_o));

  assert_deselect_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> state == FR_IDLE);

  assert_unarmed_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> state == FR_IDLE);

  assert_pause_keeps_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paused && $past(paused)) |-> $stable(bit_cnt));

  assert_pause_hiz_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused |-> !sdo_oe_o);

  assert_no_strobe_after_deselect_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_s) |-> (!rx_valid_o && !instr_valid_o));
endmodule

bind spi_hold_slave spi_hold_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_s         (cs_s),
  .paused       (paused),
  .armed_q      (armed_q),
  .sdo_oe_o     (sdo_oe_o),
  .rx_valid_o   (rx_valid_o),
  .instr_valid_o(instr_valid_o),
  .state        (state),
  .bit_cnt      (bit_cnt)
);

// File: tb/tb_spi_hold_slave.sv
module tb_spi_hold_slave;
  localparam logic [1:0] ID_HI = 2'b01;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b0, hold_n = 1'b1, sdi = 1'b0;
  logic [1:0] strap = 2'b10;
  logic rd_req = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic sdo, sdo_oe, instr_valid, rx_valid;
  logic [3:0] instr;
  logic [7:0] rx_data;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_rx[$];
  logic [3:0] exp_ins[$];

  always #5 clk = ~clk;

  spi_hold_slave #(.DEV_ID_HI(ID_HI), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .hold_ni(hold_n),
    .sdi_i(sdi), .addr_strap_i(strap), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .instr_o(instr), .instr_valid_o(instr_valid), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .rd_req_i(rd_req), .rd_data_i(rd_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_rx.size() == 0) check(1'b0, "R1 unexpected rx", {24'd0, rx_data}, 32'hFFFF);
      else begin
        logic [7:0] e;
        e = exp_rx.pop_front();
        check(rx_data == e, "R1 rx byte", {24'd0, rx_data}, {24'd0, e});
      end
    end
    if (rst_n && instr_valid) begin
      if (exp_ins.size() == 0) check(1'b0, "R2 unexpected instr", {28'd0, instr}, 32'hFFFF);
      else begin
        logic [3:0] e;
        e = exp_ins.pop_front();
        check(instr == e, "R2 instr", {28'd0, instr}, {28'd0, e});
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic so, output logic oe);
    sck = 1'b0; sdi = b;
    tick(HALF);
    so = sdo; oe = sdo_oe;
    sck = 1'b1;
    tick(HALF);
  endtask

  task automatic byte_x(input logic [7:0] tx, output logic [7:0] rd, output logic oe_all);
    logic so, oe;
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bit_x(tx[i], so, oe);
      rd[i] = so;
      oe_all &= oe;
    end
  endtask

  task automatic frame_begin();
    sck = 1'b0; cs_n = 1'b0; tick(HALF);
  endtask

  task automatic frame_end();
    sck = 1'b0; tick(HALF);
    cs_n = 1'b1; tick(HALF);
  endtask

  task automatic drain(input string req);
    tick(4);
    check(exp_rx.size() == 0 && exp_ins.size() == 0, req,
          exp_rx.size() + exp_ins.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic oe_all, so, oe;
    logic [7:0] addr_ok;
    addr_ok = {ID_HI, strap, 4'h5};

    tick(3);
    rst_n = 1'b1;
    tick(6);
    // reset state
    check(sdo_oe == 1'b0, "R4 reset oe", sdo_oe, 0);
    check(rx_valid == 1'b0 && instr_valid == 1'b0, "R5 reset strobes", {rx_valid, instr_valid}, 0);

    // R5: select already low at reset release must not arm
    rd_req = 1'b1; rd_data = 8'hFF;
    byte_x(addr_ok, rd, oe_all);
    byte_x(8'h11, rd, oe_all);
    check(oe_all == 1'b0, "R5 unarmed oe", oe_all, 0);
    rd_req = 1'b0;
    frame_end();
    drain("R5 no strobes unarmed");

    // R1/R2: matched frame, two data bytes
    exp_ins.push_back(4'h5); exp_rx.push_back(8'hA5); exp_rx.push_back(8'h3C);
    frame_begin();
    byte_x(addr_ok, rd, oe_all);
    byte_x(8'hA5, rd, oe_all);
    byte_x(8'h3C, rd, oe_all);
    frame_end();
    drain("R1 matched frame");

    // R3: mismatch on strap bit
    rd_req = 1'b1; rd_data = 8'h77;
    frame_begin();
    byte_x({ID_HI, ~strap[1], strap[0], 4'h2}, rd, oe_all);
    byte_x(8'h42, rd, oe_all);
    check(oe_all == 1'b0, "R3 mismatch oe", oe_all, 0);
    byte_x(8'h43, rd, oe_all);
    rd_req = 1'b0;
    frame_end();
    drain("R3 mismatch strobes");

    // R8: read data shifted out
    exp_ins.push_back(4'h9); exp_rx.push_back(8'h01); exp_rx.push_back(8'h02);
    rd_req = 1'b1; rd_data = 8'hC3;
    frame_begin();
    byte_x({ID_HI, strap, 4'h9}, rd, oe_all);
    rd_data = 8'h5A;
    byte_x(8'h01, rd, oe_all);
    check(rd == 8'hC3, "R8 read byte 1", rd, 8'hC3);
    check(oe_all == 1'b1, "R8 oe during read", oe_all, 1);
    rd_req = 1'b0;
    byte_x(8'h02, rd, oe_all);
    check(rd == 8'h5A, "R8 read byte 2", rd, 8'h5A);
    sck = 1'b0; tick(HALF);
    check(sdo_oe == 1'b0, "R8 no request ends drive", sdo_oe, 0);
    cs_n = 1'b1; tick(HALF);
    check(sdo_oe == 1'b0, "R4 deselect oe", sdo_oe, 0);
    drain("R8 strobes");

    // R6/R7: pause mid-byte
    exp_ins.push_back(4'h3); exp_rx.push_back(8'hB6);
    rd_req = 1'b1; rd_data = 8'h96;
    frame_begin();
    byte_x({ID_HI, strap, 4'h3}, rd, oe_all);
    rd_req = 1'b0;
    for (int i = 7; i >= 5; i--) begin
      bit_x(8'hB6 >> i, so, oe);
      rd[i] = so;
    end
    sck = 1'b0; tick(HALF);
    hold_n = 1'b0; tick(HALF);
    check(sdo_oe == 1'b0, "R7 paused oe", sdo_oe, 0);
    for (int k = 0; k < 3; k++) begin
      sdi = ~sdi; sck = 1'b1; tick(HALF);
      sck = 1'b0; tick(HALF);
    end
    hold_n = 1'b1; tick(HALF);
    check(sdo_oe == 1'b1, "R7 resume oe", sdo_oe, 1);
    for (int i = 4; i >= 0; i--) begin
      bit_x(8'hB6 >> i, so, oe);
      rd[i] = so;
    end
    check(rd == 8'h96, "R6 read across pause", rd, 8'h96);
    frame_end();
    drain("R6 byte across pause");

    // R10: hold falls while clock high, no pause
    exp_ins.push_back(4'hE); exp_rx.push_back(8'hE1);
    frame_begin();
    byte_x({ID_HI, strap, 4'hE}, rd, oe_all);
    for (int i = 7; i >= 4; i--) bit_x(8'hE1 >> i, so, oe);
    hold_n = 1'b0; tick(4);
    for (int i = 3; i >= 0; i--) bit_x(8'hE1 >> i, so, oe);
    sck = 1'b0; tick(HALF);
    hold_n = 1'b1;
    frame_end();
    drain("R10 hold in high phase");

    // R9: deselect mid-byte, then fresh frame
    exp_ins.push_back(4'h7);
    frame_begin();
    byte_x({ID_HI, strap, 4'h7}, rd, oe_all);
    for (int i = 7; i >= 3; i--) bit_x(1'b1, so, oe);
    frame_end();
    drain("R9 partial byte dropped");

    exp_ins.push_back(4'hC); exp_rx.push_back(8'h5F);
    frame_begin();
    byte_x({ID_HI, strap, 4'hC}, rd, oe_all);
    byte_x(8'h5F, rd, oe_all);
    frame_end();
    drain("R4 restart at address byte");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule